// File: doc/BRIEF.md
# Eleven-Line Interrupt Aggregator with Message Output

This block gathers eleven level-sensitive interrupt lines into a single host notification. Every line is synchronised, compared against its previous synchronised value, and any change (rising or falling) on a line that software has enabled is latched into a pending register. The first capture after the pending register was last read produces a one-cycle message strobe that carries a software-programmed 32-bit address-and-data word. The strobe stands in for a write to an external interrupt register.

Software reaches the block through a word-wide memory-mapped slave port. It programs the enable mask and the message word, and it reads pending causes, which clears them. A separate live-level register shows the synchronised state of every line whatever the mask. Software reads it after unmasking to find a line that was already held asserted while masked, since such a line raises no notification of its own.

Line assignment: bits 0 to 5 are the six PCI interrupt pins, bit 6 is an external bus interrupt, bit 7 is a default source, bit 8 is unused, bit 9 is not implemented and bit 10 is the serial-port interrupt.

Top module: `irq_msg_aggr`

## Requirements
- R1: After reset the mask register (0x018), the message register (0x004) and the pending register (0x00C) all read 0, and the message strobe is low.
- R2: Each input passes through two flops. A level driven between edges is first returned by a live-level read (0x028) issued two clock edges later. A read issued one edge later returns the old level.
- R3: A rising or a falling change on line i sets pending bit i when mask bit i is 1 and i is an implemented line. A change on a masked line sets nothing.
- R4: A read of 0x00C returns the pending bits in bits 10:0 and clears them. Only bits set in the implemented mask 0x5FF are reported, so bit 9 and bits 31:11 always read 0.
- R5: A read of 0x01C returns and clears the pending bits in the same way, and it leaves the live-level value at 0x028 unchanged.
- R6: A read of 0x028 returns the synchronised level of all eleven lines in bits 10:0, whatever the mask holds.
- R7: The mask (0x018, 11 bits, 1 = enabled) and the message word (0x004, 32 bits) are written by word writes and read back unchanged.
- R8: Setting the mask bit of a line that is already asserted and stable produces neither a pending bit nor a strobe.
- R9: The message strobe is high for exactly one cycle and carries the message word. It fires on a capture while the block is armed. Later captures made before pending is read add bits but give no strobe. A pending read re-arms the block.
- R10: Writes to 0x00C, 0x01C and 0x028 have no effect. A read of any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 11 | Asynchronous interrupt lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the request |
| msg_valid_o | output | 1 | One-cycle notification strobe |
| msg_word_o | output | 32 | Address-and-data word sent with the strobe |

## Verification
The bench sweeps every line with a rising and then a falling change. It expects pending and a strobe for each implemented line and nothing for line 9. A design that captured levels instead of edges, or that let line 9 through, would fail there. Further tests unmask a line that is already asserted, toggle a line while it is masked, and make several captures before a read. A design that fired on level, captured while masked, or strobed on every capture would show extra strobes. The bench also checks that both pending offsets clear without disturbing the live level, and it times the synchroniser to the exact edge.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int unsigned IRQ_N   = 11;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam logic [IRQ_N-1:0] IMPL_MASK = 11'h5FF;

  localparam logic [ADDR_W-1:0] OFS_MSG   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_PEND2 = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_LVL   = 12'h028;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int unsigned N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g]   <= 1'b0;
        s2_q[g]   <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        s1_q[g]   <= irq_i[g];
        s2_q[g]   <= s1_q[g];
        prev_q[g] <= s2_q[g];
      end
    end
    assign chg_o[g] = s2_q[g] ^ prev_q[g];
  end

  assign lvl_o = s2_q;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int unsigned N = 11,
  parameter logic [N-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] chg_i,
  input  logic [N-1:0] mask_i,
  input  logic         rd_clr_i,
  output logic [N-1:0] pend_o,
  output logic         msg_valid_o
);
  logic [N-1:0] pend_q, set;
  logic         armed_q, fire, msg_q;

  assign set  = chg_i & mask_i & IMPL;
  assign fire = armed_q && (|set);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      armed_q <= 1'b1;
      msg_q   <= 1'b0;
    end else begin
      // a capture in the read cycle survives the clear
      pend_q <= (rd_clr_i ? '0 : pend_q) | set;
      msg_q  <= fire;
      if (fire)          armed_q <= 1'b0;
      else if (rd_clr_i) armed_q <= 1'b1;
    end
  end

  assign pend_o      = pend_q;
  assign msg_valid_o = msg_q;

  AST_MSG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |=> !msg_valid_o); // R9
  AST_MSG_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> ($past(chg_i & mask_i & IMPL) != '0)); // R8
  AST_PEND_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && (chg_i & mask_i) == '0) |=> (pend_o == '0)); // R4
  AST_MASKED_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~($past(chg_i) & $past(mask_i))) == '0)); // R3
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_aggr_pkg::*;
#(
  parameter int unsigned N = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      pend_i,
  input  logic [N-1:0]      lvl_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N-1:0]      mask_o,
  output logic [DATA_W-1:0] msg_o,
  output logic              rd_clr_o
);
  localparam int unsigned PAD = DATA_W - N;

  logic [N-1:0]      mask_q;
  logic [DATA_W-1:0] msg_q, rdata_q, rmux;
  logic              rd, wr;

  assign rd       = req_i && !we_i;
  assign wr       = req_i && we_i;
  assign rd_clr_o = rd && (addr_i == OFS_PEND || addr_i == OFS_PEND2);

  always_comb begin
    unique case (addr_i)
      OFS_MSG:             rmux = msg_q;
      OFS_MASK:            rmux = {{PAD{1'b0}}, mask_q};
      OFS_PEND, OFS_PEND2: rmux = {{PAD{1'b0}}, pend_i};
      OFS_LVL:             rmux = {{PAD{1'b0}}, lvl_i};
      default:             rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      msg_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr && addr_i == OFS_MASK) mask_q <= wdata_i[N-1:0];
      if (wr && addr_i == OFS_MSG)  msg_q  <= wdata_i;
      if (rd)                       rdata_q <= rmux;
    end
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign msg_o   = msg_q;

  AST_RO_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == OFS_MASK) |=> $stable(mask_o)); // R10
endmodule

// File: rtl/irq_msg_aggr.sv
module irq_msg_aggr
  import irq_aggr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IRQ_N-1:0]  irq_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              msg_valid_o,
  output logic [DATA_W-1:0] msg_word_o
);
  logic [IRQ_N-1:0] lvl, chg, mask, pend;
  logic             rd_clr;

  irq_line_sync #(.N(IRQ_N)) u_sync (
    .clk_i, .rst_ni, .irq_i, .lvl_o(lvl), .chg_o(chg)
  );

  irq_pend_ctrl #(.N(IRQ_N), .IMPL(IMPL_MASK)) u_pend (
    .clk_i, .rst_ni, .chg_i(chg), .mask_i(mask), .rd_clr_i(rd_clr),
    .pend_o(pend), .msg_valid_o
  );

  irq_reg_file #(.N(IRQ_N)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .pend_i(pend), .lvl_i(lvl), .rdata_o, .mask_o(mask), .msg_o(msg_word_o),
    .rd_clr_o(rd_clr)
  );

  AST_PEND_BIT9_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_PEND) |=> (rdata_o[DATA_W-1:9] == '0 || rdata_o[9] == 1'b0)); // R4
endmodule

// File: tb/irq_msg_aggr_tb.sv
module irq_msg_aggr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, msg_word;
  logic        msg_valid;

  int errs = 0, checks = 0, strobes = 0, bad_word = 0, prev_hi = 0;
  logic [31:0] exp_word = '0;

  always #5 clk = ~clk;

  irq_msg_aggr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .msg_valid_o(msg_valid), .msg_word_o(msg_word)
  );

  always @(negedge clk) begin
    if (msg_valid) begin
      strobes++;
      if (msg_word !== exp_word) bad_word++;
      if (prev_hi) bad_word++;
    end
    prev_hi = msg_valid;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(posedge clk); @(negedge clk); d = rdata; req = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  logic [31:0] v, v2;

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 strobe low", {31'b0, msg_valid}, 0);
    rd(12'h018, v); chk("R1 mask reset", v, 0);
    rd(12'h004, v); chk("R1 msg reset", v, 0);
    rd(12'h00C, v); chk("R1 pend reset", v, 0);

    exp_word = 32'hCAFE_1234;
    wr(12'h004, exp_word);
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, v); chk("R7 mask readback", v, 32'h7FF);
    rd(12'h004, v); chk("R7 msg readback", v, exp_word);

    // sweep every line, rising then falling
    for (int i = 0; i < 11; i++) begin
      for (int e = 0; e < 2; e++) begin
        strobes = 0;
        @(negedge clk); irq[i] = (e == 0);
        settle();
        chk($sformatf("R9 strobe count line %0d edge %0d", i, e), strobes, (i == 9) ? 0 : 1);
        rd(12'h00C, v);
        chk($sformatf("R3 R4 pend line %0d edge %0d", i, e), v, (32'h1 << i) & 32'h5FF);
        rd(12'h00C, v); chk("R4 cleared after read", v, 0);
        rd(12'h028, v); chk("R6 level sweep", v, {21'b0, irq});
      end
    end
    chk("R9 strobe word and width", bad_word, 0);

    // masked line toggles: nothing captured, level still visible
    wr(12'h018, 32'h0);
    strobes = 0;
    @(negedge clk); irq[3] = 1'b1;
    settle();
    chk("R3 masked no strobe", strobes, 0);
    rd(12'h00C, v); chk("R3 masked no pend", v, 0);
    rd(12'h028, v); chk("R6 level while masked", v, 32'h8);

    // unmask an already asserted line
    wr(12'h018, 32'h7FF);
    settle();
    chk("R8 unmask asserted no strobe", strobes, 0);
    rd(12'h00C, v); chk("R8 unmask asserted no pend", v, 0);

    // several captures before a read: one strobe
    @(negedge clk); irq[0] = 1'b1;
    settle();
    @(negedge clk); irq[1] = 1'b1;
    settle();
    chk("R9 single strobe for two captures", strobes, 1);
    rd(12'h00C, v); chk("R9 accumulated pend", v, 32'h3);
    @(negedge clk); irq[2] = 1'b1;
    settle();
    chk("R9 rearm after read", strobes, 2);

    // second pending offset
    rd(12'h028, v2);
    rd(12'h01C, v); chk("R5 alt read returns pend", v, 32'h4);
    rd(12'h00C, v); chk("R5 alt read cleared", v, 0);
    rd(12'h028, v); chk("R5 level unchanged", v, v2);

    // ignored writes and unmapped read
    @(negedge clk); irq[4] = 1'b1;
    settle();
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h01C, 32'h0);
    wr(12'h028, 32'h0);
    rd(12'h028, v); chk("R10 level write ignored", v, {21'b0, irq});
    rd(12'h00C, v); chk("R10 pend write ignored", v, 32'h10);
    rd(12'h040, v); chk("R10 unmapped read", v, 0);

    // synchroniser latency
    @(negedge clk); irq[6] = 1'b1;
    @(negedge clk); req = 1; we = 0; addr = 12'h028;
    @(posedge clk); @(negedge clk); v = rdata;
    @(posedge clk); @(negedge clk); v2 = rdata; req = 0;
    chk("R2 one edge old level", v[6], 0);
    chk("R2 two edges new level", v2[6], 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule